// File: doc/BRIEF.md
# Per-Thread Wait and Delay Stall Unit

This block sits beside the issue stage of a multi-threaded core whose threads take turns in time slots. In each slot the issue logic presents the index of the thread that owns the slot and the stall command decoded from that thread's current instruction. The block answers with a single hold signal. When hold is high the instruction does not retire, and the thread presents the same instruction again in its next slot.

Two commands are blocking waits. One waits for a low level and the other for a high level. Each polls one selected bit, which comes either from the I/O pin vector or from a shared general-purpose bit vector that threads use to signal each other. The third command is a delay. Its 8-bit operand counts slots owned by the stalled thread, so the delay in wall-clock time scales with that thread's share of the issue bandwidth.

Every thread has its own delay counter. A stalled thread therefore never blocks another thread. A thread's pending delay can be cancelled when its program counter is overwritten from outside or when the thread is disabled.

Top module: `thread_stall_unit`

## Requirements
- R1: After reset no thread has a pending delay, and hold is 0.
- R2: Command code 2'b01 (wait-low): in the owning slot, hold is 1 while the selected bit reads 1, and hold is 0 in any slot where it reads 0.
- R3: Command code 2'b10 (wait-high): in the owning slot, hold is 1 while the selected bit reads 0, and hold is 0 in any slot where it reads 1.
- R4: Source select 0 picks io_in[sel_idx]. Source select 1 picks gp_in indexed by the low log2(GP_W) bits of sel_idx.
- R5: Command code 2'b11 (delay) with an operand of 0 retires in its first slot with no hold.
- R6: A delay with operand N in 1..255 holds the thread for exactly N of its own slots and retires in its N+1-th slot.
- R7: Slots owned by other threads, and cycles with slot_valid low, neither advance nor clear a thread's delay. They also never see that thread's hold.
- R8: cancel_i[t] high for one cycle clears any pending delay of thread t. The next delay command of that thread starts afresh from its operand.
- R9: A command other than delay (code 2'b00, 2'b01 or 2'b10) in a thread's own slot drops that thread's pending delay.
- R10: hold is 0 when slot_valid is 0 or when the command is 2'b00 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid | input | 1 | A thread owns the current slot |
| slot_tid | input | TID_W | Index of the owning thread |
| cmd | input | 2 | 00 none, 01 wait-low, 10 wait-high, 11 delay |
| sel_src | input | 1 | 0 selects the I/O vector, 1 selects the general-purpose vector |
| sel_idx | input | SEL_W | Bit index for the waits |
| dly_val | input | DLY_W | Delay operand |
| io_in | input | IO_W | I/O pin levels |
| gp_in | input | GP_W | Shared general-purpose bits |
| cancel_i | input | NUM_THR | Per-thread cancel (PC overwrite or disable) |
| hold | output | 1 | Current instruction must not retire |

## Verification
The bench builds the block with its defaults: eight threads, a 16-bit I/O vector, an 8-bit general-purpose vector and an 8-bit delay. A 4-bit index then reaches past the end of the general-purpose vector, which exercises the low-bit folding of R4. The 8-bit delay brings the full operand of 255 and the zero operand into a short run. Interleaving slots of several threads shows that the counters stay independent.

// File: rtl/stall_pkg.sv
package stall_pkg;
    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_WAIT_LO = 2'b01,
        CMD_WAIT_HI = 2'b10,
        CMD_DELAY   = 2'b11
    } stall_cmd_e;
endpackage

// File: rtl/stall_bit_pick.sv
module stall_bit_pick #(
    parameter int IO_W  = 16,
    parameter int GP_W  = 8,
    parameter int SEL_W = $clog2(IO_W)
) (
    input  logic             src_i,
    input  logic [SEL_W-1:0] idx_i,
    input  logic [IO_W-1:0]  io_i,
    input  logic [GP_W-1:0]  gp_i,
    output logic             bit_o
);
    localparam int GP_SEL_W = $clog2(GP_W);

    logic [GP_SEL_W-1:0] gp_idx;

    always_comb begin
        gp_idx = idx_i[GP_SEL_W-1:0];
        bit_o  = src_i ? gp_i[gp_idx] : io_i[idx_i];
    end
endmodule

// File: rtl/stall_delay_ctr.sv
module stall_delay_ctr #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_hit_i,
    input  logic             slot_other_i,
    input  logic             cancel_i,
    input  logic [DLY_W-1:0] load_i,
    output logic             hold_o,
    output logic             busy_o
);
    typedef struct packed {
        logic             busy;
        logic [DLY_W-1:0] cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        hold_o = 1'b0;
        if (slot_hit_i) begin
            if (!st_q.busy) begin
                if (load_i != '0) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = load_i - 1'b1;
                    hold_o    = 1'b1;
                end
            end else if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
                hold_o   = 1'b1;
            end
        end else if (slot_other_i) begin
            st_d.busy = 1'b0;
        end
        if (cancel_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    assert_cancel_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_i |=> !st_q.busy);

    assert_count_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_hit_i && st_q.busy && st_q.cnt != '0 && !cancel_i)
        |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - 1'b1));

    assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_hit_i && !slot_other_i && !cancel_i) |=> $stable(st_q));

    assert_other_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_other_i |=> !st_q.busy);
endmodule

// File: rtl/thread_stall_unit.sv
module thread_stall_unit
    import stall_pkg::*;
#(
    parameter int NUM_THR = 8,
    parameter int IO_W    = 16,
    parameter int GP_W    = 8,
    parameter int DLY_W   = 8,
    parameter int TID_W   = $clog2(NUM_THR),
    parameter int SEL_W   = $clog2(IO_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_valid,
    input  logic [TID_W-1:0]   slot_tid,
    input  logic [1:0]         cmd,
    input  logic               sel_src,
    input  logic [SEL_W-1:0]   sel_idx,
    input  logic [DLY_W-1:0]   dly_val,
    input  logic [IO_W-1:0]    io_in,
    input  logic [GP_W-1:0]    gp_in,
    input  logic [NUM_THR-1:0] cancel_i,
    output logic               hold
);
    stall_cmd_e         cmd_e;
    logic               pick_bit;
    logic [NUM_THR-1:0] dly_hold;
    logic [NUM_THR-1:0] dly_busy;

    assign cmd_e = stall_cmd_e'(cmd);

    stall_bit_pick #(.IO_W(IO_W), .GP_W(GP_W), .SEL_W(SEL_W)) u_pick (
        .src_i (sel_src),
        .idx_i (sel_idx),
        .io_i  (io_in),
        .gp_i  (gp_in),
        .bit_o (pick_bit)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic own;
        assign own = slot_valid && (slot_tid == TID_W'(t));

        stall_delay_ctr #(.DLY_W(DLY_W)) u_ctr (
            .clk          (clk),
            .rst_n        (rst_n),
            .slot_hit_i   (own && cmd_e == CMD_DELAY),
            .slot_other_i (own && cmd_e != CMD_DELAY),
            .cancel_i     (cancel_i[t]),
            .load_i       (dly_val),
            .hold_o       (dly_hold[t]),
            .busy_o       (dly_busy[t])
        );
    end

    always_comb begin
        hold = 1'b0;
        if (slot_valid) begin
            unique case (cmd_e)
                CMD_WAIT_LO: hold = pick_bit;
                CMD_WAIT_HI: hold = !pick_bit;
                CMD_DELAY:   hold = dly_hold[slot_tid];
                default:     hold = 1'b0;
            endcase
        end
    end

    assert_wait_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && cmd_e == CMD_WAIT_LO && !pick_bit) |-> !hold);

    assert_wait_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && cmd_e == CMD_WAIT_HI && pick_bit) |-> !hold);

    assert_zero_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && cmd_e == CMD_DELAY && dly_val == '0 && !dly_busy[slot_tid]) |-> !hold);

    assert_idle_no_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_valid || cmd_e == CMD_NONE) |-> !hold);
endmodule

// File: tb/thread_stall_unit_tb.sv
module thread_stall_unit_tb;
    localparam int CLK_P = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       slot_valid = 0;
    logic [2:0] slot_tid = '0;
    logic [1:0] cmd = '0;
    logic       sel_src = 0;
    logic [3:0] sel_idx = '0;
    logic [7:0] dly_val = '0;
    logic [15:0] io_in = '0;
    logic [7:0] gp_in = '0;
    logic [7:0] cancel_i = '0;
    logic       hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    thread_stall_unit u_dut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_tid(slot_tid),
        .cmd(cmd), .sel_src(sel_src), .sel_idx(sel_idx), .dly_val(dly_val),
        .io_in(io_in), .gp_in(gp_in), .cancel_i(cancel_i), .hold(hold)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s hold=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one slot after the falling edge and sample hold before the rising edge.
    task automatic issue(input logic v, input int tid, input logic [1:0] c,
                         input logic src, input int idx, input int cnt, output logic h);
        @(negedge clk);
        cancel_i   = '0;
        slot_valid = v;
        slot_tid   = 3'(tid);
        cmd        = c;
        sel_src    = src;
        sel_idx    = 4'(idx);
        dly_val    = 8'(cnt);
        #1 h = hold;
    endtask

    task automatic pulse_cancel(input logic [7:0] m);
        @(negedge clk);
        slot_valid = 0;
        cmd        = 2'b00;
        cancel_i   = m;
        @(negedge clk);
        cancel_i   = '0;
    endtask

    task automatic t_reset;
        logic h;
        #1 check("R1", hold, 1'b0);
        issue(1, 3, 2'b11, 0, 0, 0, h);
        check("R1", h, 1'b0);
        check("R5", h, 1'b0);
    endtask

    task automatic t_wait_low;
        logic h;
        io_in = 16'h0020;
        issue(1, 0, 2'b01, 0, 5, 0, h); check("R2", h, 1'b1);
        issue(1, 0, 2'b01, 0, 5, 0, h); check("R2", h, 1'b1);
        io_in = 16'h0000;
        issue(1, 0, 2'b01, 0, 5, 0, h); check("R2", h, 1'b0);
    endtask

    task automatic t_wait_high_src;
        logic h;
        io_in = 16'h0000;
        gp_in = 8'h04;
        issue(1, 2, 2'b10, 1, 2, 0, h);  check("R3", h, 1'b0);
        issue(1, 2, 2'b10, 0, 2, 0, h);  check("R4", h, 1'b1);
        issue(1, 2, 2'b10, 1, 10, 0, h); check("R4", h, 1'b0);
        gp_in = 8'h00;
        issue(1, 2, 2'b10, 1, 10, 0, h); check("R3", h, 1'b1);
    endtask

    // Thread 1 delays 3 and thread 2 delays 2 in interleaved slots.
    task automatic t_interleave;
        logic h;
        for (int i = 0; i < 4; i++) begin
            issue(1, 1, 2'b11, 0, 0, 3, h);
            check("R6", h, i < 3);
            if (i < 3) begin
                issue(1, 2, 2'b11, 0, 0, 2, h);
                check("R7", h, i < 2);
            end
            issue(0, 1, 2'b11, 0, 0, 3, h);
            check("R10", h, 1'b0);
        end
    endtask

    task automatic t_full_delay;
        logic h;
        int held = 0;
        for (int i = 0; i < 256; i++) begin
            issue(1, 7, 2'b11, 0, 0, 255, h);
            if (h) held++;
        end
        checks++;
        if (held != 255) begin
            errors++;
            $display("FAIL R6 held=%0d expected=255", held);
        end
        issue(1, 7, 2'b11, 0, 0, 0, h);
        check("R5", h, 1'b0);
    endtask

    task automatic t_cancel;
        logic h;
        issue(1, 4, 2'b11, 0, 0, 5, h); check("R8", h, 1'b1);
        issue(1, 4, 2'b11, 0, 0, 5, h); check("R8", h, 1'b1);
        pulse_cancel(8'h10);
        for (int i = 0; i < 3; i++) begin
            issue(1, 4, 2'b11, 0, 0, 2, h);
            check("R8", h, i < 2);
        end
    endtask

    task automatic t_other_cmd;
        logic h;
        issue(1, 5, 2'b11, 0, 0, 4, h); check("R9", h, 1'b1);
        issue(1, 5, 2'b00, 0, 0, 4, h); check("R10", h, 1'b0);
        issue(1, 5, 2'b11, 0, 0, 1, h); check("R9", h, 1'b1);
        issue(1, 5, 2'b11, 0, 0, 1, h); check("R9", h, 1'b0);
    endtask

    task automatic t_invalid_slot;
        logic h;
        issue(1, 6, 2'b11, 0, 0, 2, h); check("R7", h, 1'b1);
        for (int i = 0; i < 3; i++) begin
            issue(0, 6, 2'b11, 0, 0, 2, h);
            check("R10", h, 1'b0);
        end
        issue(1, 6, 2'b11, 0, 0, 2, h); check("R7", h, 1'b1);
        issue(1, 6, 2'b11, 0, 0, 2, h); check("R7", h, 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #(CLK_P * 2 + 2);
        t_reset();
        rst_n = 1;
        t_reset();
        t_wait_low();
        t_wait_high_src();
        t_interleave();
        t_full_delay();
        t_cancel();
        t_other_cmd();
        t_invalid_slot();
        finish_run();
    end
endmodule